// File: doc/BRIEF.md
# Store Queue with Age-Qualified Forwarding Lookup

This block holds the stores that are in flight next to the data cache. Each store gets an entry at dispatch. Its address and its value arrive later and in any order. Once a store retires, the entry is written to the cache. Writes leave strictly from the oldest entry, one per cache handshake. The entries form a circular queue between a head pointer and a tail pointer. The pointers are one bit wider than the index, so a full queue can be told apart from an empty one.

A load presents its word address together with its queue position. The position is the tail pointer value that the load saw when it was dispatched. In the same cycle, and so alongside the cache access, every store older than that position is compared with the load. The block returns one of three answers:

- forward the value of the youngest older matching store;
- no older store can match, so the cache supplies the value;
- wait, because an older store's address is unknown in a place that matters, or because the matching store has no value yet.

The retirement side is a two-state drain machine. In DRAIN_IDLE no cache write is offered. The IDLE-to-SEND transition fires when a committed entry sits at the head. In DRAIN_SEND the head entry is offered to the cache until it is accepted. The SEND-to-SEND transition fires on acceptance while more committed entries remain. The SEND-to-IDLE transition fires on acceptance of the last committed entry.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` is 1, `alloc_ptr` is 0, `cache_wr_valid` is 0 and `ld_verdict` is 0.
- R2: An allocation accepted while `alloc_ready` is 1 takes the entry named by `alloc_ptr`, and `alloc_ptr` then advances by one. When DEPTH entries are held, `alloc_ready` is 0 and an allocation request leaves `alloc_ptr` unchanged.
- R3: `ld_verdict` is combinational in the lookup cycle and uses this encoding: 0 means no load presented, 1 means forward, 2 means the cache supplies the data, 3 means wait. `ld_data` carries the forwarded value when the verdict is 1.
- R4: Only stores at pointer positions from the head up to `ld_pos`-1 take part in a lookup.
- R5: When several older stores match the load address, the youngest of them supplies `ld_data`.
- R6: With no older matching store and no older unknown address, the verdict is 2.
- R7: An older store with an unknown address gives verdict 3 when it is younger than the youngest match, or when there is no match. When the unknown address belongs to a store older than the youngest match, it has no effect.
- R8: When the youngest older match has no value yet, the verdict is 3.
- R9: Each `retire_valid` pulse commits the next uncommitted entry in program order. A pulse with no uncommitted entry is ignored. Committed entries are offered to the cache from the head in order. `cache_wr_valid` and the address are held until `cache_wr_ready` is seen.
- R10: Age qualification stays correct after the pointers wrap past the end of the storage.
- R11: A reused slot starts with an unknown address and no value.
- R12: A store accepted by the cache frees its slot, so `alloc_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store entry at the tail |
| alloc_ready | output | 1 | Queue has a free entry |
| alloc_ptr | output | PTR_W | Pointer given to the next allocation |
| sta_valid | input | 1 | Store address write |
| sta_idx | input | IDX_W | Entry index for the address |
| sta_addr | input | ADDR_W | Store word address |
| std_valid | input | 1 | Store value write |
| std_idx | input | IDX_W | Entry index for the value |
| std_data | input | DATA_W | Store value |
| retire_valid | input | 1 | Commit the next store |
| ld_valid | input | 1 | Load lookup present |
| ld_addr | input | ADDR_W | Load word address |
| ld_pos | input | PTR_W | Tail pointer seen at the load's dispatch |
| ld_verdict | output | 2 | Lookup outcome |
| ld_data | output | DATA_W | Forwarded value |
| cache_wr_valid | output | 1 | Cache write offered |
| cache_wr_ready | input | 1 | Cache accepts the write |
| cache_wr_addr | output | ADDR_W | Cache write address |
| cache_wr_data | output | DATA_W | Cache write value |

## Verification
The hardest case to reach is a lookup after the pointers have wrapped. In that case the oldest in-scope store has a higher index than younger ones. The bench fills and drains six stores first. It then allocates a full queue, which spans the end of the storage, and presents load positions that cut the window across the wrap. A second hard case is an unknown address placed between two matching stores. The stimulus therefore writes addresses out of order and leaves one address and one value missing. It fills them only after the ambiguous verdicts have been checked.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'd0,
        VERDICT_FWD   = 2'd1,
        VERDICT_CACHE = 2'd2,
        VERDICT_WAIT  = 2'd3
    } verdict_e;

    typedef enum logic {
        DRAIN_IDLE = 1'b0,
        DRAIN_SEND = 1'b1
    } drain_state_e;

endpackage

// File: rtl/sqf_entry_array.sv
module sqf_entry_array #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [IDX_W-1:0]              alloc_idx,
    input  logic                          free_en,
    input  logic [IDX_W-1:0]              free_idx,
    input  logic                          sta_en,
    input  logic [IDX_W-1:0]              sta_idx,
    input  logic [ADDR_W-1:0]             sta_addr,
    input  logic                          std_en,
    input  logic [IDX_W-1:0]              std_idx,
    input  logic [DATA_W-1:0]             std_data,
    output logic [DEPTH-1:0]              busy,
    output logic [DEPTH-1:0]              addr_ok,
    output logic [DEPTH-1:0]              data_ok,
    output logic [DEPTH-1:0][ADDR_W-1:0]  addr_q,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_q
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic hit_alloc;
        logic hit_free;
        logic hit_sta;
        logic hit_std;

        assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(i));
        assign hit_free  = free_en  && (free_idx  == IDX_W'(i));
        assign hit_sta   = sta_en   && (sta_idx   == IDX_W'(i)) && busy[i];
        assign hit_std   = std_en   && (std_idx   == IDX_W'(i)) && busy[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[i]    <= 1'b0;
                addr_ok[i] <= 1'b0;
                data_ok[i] <= 1'b0;
                addr_q[i]  <= '0;
                data_q[i]  <= '0;
            end else if (hit_alloc) begin
                // a reused slot starts unknown
                busy[i]    <= 1'b1;
                addr_ok[i] <= 1'b0;
                data_ok[i] <= 1'b0;
            end else begin
                if (hit_free) begin
                    busy[i] <= 1'b0;
                end
                if (hit_sta) begin
                    addr_ok[i] <= 1'b1;
                    addr_q[i]  <= sta_addr;
                end
                if (hit_std) begin
                    data_ok[i] <= 1'b1;
                    data_q[i]  <= std_data;
                end
            end
        end
    end

    // R2
    alloc_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !busy[alloc_idx]);

    // R12
    free_busy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> busy[free_idx]);

endmodule

// File: rtl/sqf_age_search.sv
module sqf_age_search
    import sqf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int PTR_W  = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_valid,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [PTR_W-1:0]              ld_pos,
    input  logic [PTR_W-1:0]              head_ptr,
    input  logic [PTR_W-1:0]              tail_ptr,
    input  logic [DEPTH-1:0]              busy,
    input  logic [DEPTH-1:0]              addr_ok,
    input  logic [DEPTH-1:0]              data_ok,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q,
    input  logic [DEPTH-1:0][DATA_W-1:0]  data_q,
    output verdict_e                      verdict,
    output logic [DATA_W-1:0]             fwd_data
);

    logic [PTR_W-1:0] held;
    logic [PTR_W-1:0] older_raw;
    logic [PTR_W-1:0] older;
    logic [IDX_W-1:0] head_idx;

    assign held      = tail_ptr - head_ptr;
    assign older_raw = ld_pos - head_ptr;
    assign older     = (older_raw > held) ? held : older_raw;
    assign head_idx  = head_ptr[IDX_W-1:0];

    // entries re-ordered by age: rank 0 is the head
    logic [DEPTH-1:0]             rank_unknown;
    logic [DEPTH-1:0]             rank_hit;
    logic [DEPTH-1:0]             rank_ready;
    logic [DEPTH-1:0][DATA_W-1:0] rank_data;

    for (genvar k = 0; k < DEPTH; k++) begin : g_rank
        logic [IDX_W-1:0] slot;
        logic             in_scope;

        assign slot            = head_idx + IDX_W'(k);
        assign in_scope        = busy[slot] && (PTR_W'(k) < older);
        assign rank_unknown[k] = in_scope && !addr_ok[slot];
        assign rank_hit[k]     = in_scope && addr_ok[slot] && (addr_q[slot] == ld_addr);
        assign rank_ready[k]   = data_ok[slot];
        assign rank_data[k]    = data_q[slot];
    end

    logic              found_hit;
    logic              found_unknown;
    logic              hit_ready;
    logic [DATA_W-1:0] hit_data;

    // scan from oldest to youngest: a younger event overrides an older one
    always_comb begin
        found_hit     = 1'b0;
        found_unknown = 1'b0;
        hit_ready     = 1'b0;
        hit_data      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rank_unknown[k]) begin
                found_unknown = 1'b1;
            end else if (rank_hit[k]) begin
                found_hit     = 1'b1;
                found_unknown = 1'b0;
                hit_ready     = rank_ready[k];
                hit_data      = rank_data[k];
            end
        end
    end

    always_comb begin
        if (!ld_valid) begin
            verdict = VERDICT_NONE;
        end else if (found_unknown) begin
            verdict = VERDICT_WAIT;
        end else if (found_hit) begin
            verdict = hit_ready ? VERDICT_FWD : VERDICT_WAIT;
        end else begin
            verdict = VERDICT_CACHE;
        end
    end

    assign fwd_data = (verdict == VERDICT_FWD) ? hit_data : '0;

    // R4
    fwd_needs_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VERDICT_FWD) |-> (older != '0));

    // R6
    empty_goes_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && held == '0) |-> (verdict == VERDICT_CACHE));

endmodule

// File: rtl/sqf_drain_fsm.sv
module sqf_drain_fsm
    import sqf_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_valid,
    input  logic [PTR_W-1:0] tail_ptr,
    input  logic             cache_wr_ready,
    output logic [PTR_W-1:0] head_ptr,
    output logic [PTR_W-1:0] commit_ptr,
    output logic             pop,
    output logic             cache_wr_valid
);

    drain_state_e state_q;
    drain_state_e state_d;
    logic         commit_fire;
    logic         more_after_pop;

    assign commit_fire    = retire_valid && (commit_ptr != tail_ptr);
    assign more_after_pop = (head_ptr + PTR_W'(1)) != commit_ptr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRAIN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRAIN_IDLE: if (commit_ptr != head_ptr) state_d = DRAIN_SEND;
            DRAIN_SEND: if (cache_wr_ready && !more_after_pop) state_d = DRAIN_IDLE;
            default:    state_d = DRAIN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cache_wr_valid = 1'b0;
        pop            = 1'b0;
        unique case (state_q)
            DRAIN_IDLE: ;
            DRAIN_SEND: begin
                cache_wr_valid = 1'b1;
                pop            = cache_wr_ready;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr   <= '0;
            commit_ptr <= '0;
        end else begin
            if (pop)         head_ptr   <= head_ptr + PTR_W'(1);
            if (commit_fire) commit_ptr <= commit_ptr + PTR_W'(1);
        end
    end

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_valid && !cache_wr_ready) |=> (cache_wr_valid && $stable(head_ptr)));

    // R9
    drain_committed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid |-> (head_ptr != commit_ptr));

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
    import sqf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int PTR_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    output logic [PTR_W-1:0]  alloc_ptr,
    input  logic              sta_valid,
    input  logic [IDX_W-1:0]  sta_idx,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic              std_valid,
    input  logic [IDX_W-1:0]  std_idx,
    input  logic [DATA_W-1:0] std_data,
    input  logic              retire_valid,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PTR_W-1:0]  ld_pos,
    output logic [1:0]        ld_verdict,
    output logic [DATA_W-1:0] ld_data,
    output logic              cache_wr_valid,
    input  logic              cache_wr_ready,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data
);

    localparam logic [PTR_W-1:0] FULL_COUNT = PTR_W'(DEPTH);

    logic [PTR_W-1:0] tail_ptr;
    logic [PTR_W-1:0] head_ptr;
    logic [PTR_W-1:0] commit_ptr;
    logic [PTR_W-1:0] held;
    logic             alloc_fire;
    logic             pop;

    logic [DEPTH-1:0]             busy;
    logic [DEPTH-1:0]             addr_ok;
    logic [DEPTH-1:0]             data_ok;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    verdict_e                     verdict;

    assign held        = tail_ptr - head_ptr;
    assign alloc_ready = (held != FULL_COUNT);
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_ptr   = tail_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_ptr <= '0;
        end else if (alloc_fire) begin
            tail_ptr <= tail_ptr + PTR_W'(1);
        end
    end

    sqf_entry_array #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc_fire),
        .alloc_idx(tail_ptr[IDX_W-1:0]),
        .free_en  (pop),
        .free_idx (head_ptr[IDX_W-1:0]),
        .sta_en   (sta_valid),
        .sta_idx  (sta_idx),
        .sta_addr (sta_addr),
        .std_en   (std_valid),
        .std_idx  (std_idx),
        .std_data (std_data),
        .busy     (busy),
        .addr_ok  (addr_ok),
        .data_ok  (data_ok),
        .addr_q   (addr_q),
        .data_q   (data_q)
    );

    sqf_age_search #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W),
        .PTR_W (PTR_W)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_valid(ld_valid),
        .ld_addr (ld_addr),
        .ld_pos  (ld_pos),
        .head_ptr(head_ptr),
        .tail_ptr(tail_ptr),
        .busy    (busy),
        .addr_ok (addr_ok),
        .data_ok (data_ok),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .verdict (verdict),
        .fwd_data(ld_data)
    );

    assign ld_verdict = verdict;

    sqf_drain_fsm #(
        .IDX_W(IDX_W),
        .PTR_W(PTR_W)
    ) u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .retire_valid  (retire_valid),
        .tail_ptr      (tail_ptr),
        .cache_wr_ready(cache_wr_ready),
        .head_ptr      (head_ptr),
        .commit_ptr    (commit_ptr),
        .pop           (pop),
        .cache_wr_valid(cache_wr_valid)
    );

    assign cache_wr_addr = addr_q[head_ptr[IDX_W-1:0]];
    assign cache_wr_data = data_q[head_ptr[IDX_W-1:0]];

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held <= FULL_COUNT);

    // R9
    commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ptr - head_ptr) <= held);

    // R2
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && held == FULL_COUNT) |=> $stable(alloc_ptr));

endmodule

// File: tb/test_store_fwd_queue.sv
`timescale 1ns/1ps
module test_store_fwd_queue;

    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IW = 3;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic          alloc_ready;
    logic [PW-1:0] alloc_ptr;
    logic          sta_valid = 1'b0;
    logic [IW-1:0] sta_idx = '0;
    logic [AW-1:0] sta_addr = '0;
    logic          std_valid = 1'b0;
    logic [IW-1:0] std_idx = '0;
    logic [DW-1:0] std_data = '0;
    logic          retire_valid = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [PW-1:0] ld_pos = '0;
    logic [1:0]    ld_verdict;
    logic [DW-1:0] ld_data;
    logic          cache_wr_valid;
    logic          cache_wr_ready = 1'b0;
    logic [AW-1:0] cache_wr_addr;
    logic [DW-1:0] cache_wr_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    store_fwd_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_store_fwd_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_ptr(alloc_ptr),
        .sta_valid(sta_valid), .sta_idx(sta_idx), .sta_addr(sta_addr),
        .std_valid(std_valid), .std_idx(std_idx), .std_data(std_data),
        .retire_valid(retire_valid),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_pos(ld_pos),
        .ld_verdict(ld_verdict), .ld_data(ld_data),
        .cache_wr_valid(cache_wr_valid), .cache_wr_ready(cache_wr_ready),
        .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data)
    );

    // verdict codes: 1 forward, 2 cache, 3 wait
    localparam int NV = 9;
    localparam logic [AW-1:0] V_ADDR [NV] = '{32'h100, 32'h100, 32'h100, 32'h200, 32'h300,
                                              32'h400, 32'h400, 32'h100, 32'h200};
    localparam logic [PW-1:0] V_POS  [NV] = '{4'd6, 4'd3, 4'd2, 4'd6, 4'd5, 4'd3, 4'd6, 4'd0, 4'd2};
    localparam logic [1:0]    V_VERD [NV] = '{2'd3, 2'd1, 2'd1, 2'd1, 2'd3, 2'd2, 2'd3, 2'd2, 2'd1};
    localparam logic [DW-1:0] V_DATA [NV] = '{32'h0, 32'hA2, 32'hA0, 32'hA5, 32'h0,
                                              32'h0, 32'h0, 32'h0, 32'hA1};
    // R7, R5, R4, R7, R8, R6, R7, R4, R5
    string v_tag [NV] = '{"R7", "R5", "R4", "R7", "R8", "R6", "R7", "R4", "R5"};

    logic [AW-1:0] exp_a [14] = '{32'h100, 32'h200, 32'h100, 32'h500, 32'h300, 32'h200,
                                 32'h700, 32'h700, 32'h800, 32'h900, 32'h904, 32'h908,
                                 32'h90C, 32'h910};
    logic [DW-1:0] exp_d [14] = '{32'hA0, 32'hA1, 32'hA2, 32'hA3, 32'hA4, 32'hA5,
                                 32'hB0, 32'hB1, 32'hB2, 32'hB3, 32'hB4, 32'hB5,
                                 32'hB6, 32'hB7};

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_alloc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            alloc_valid = 1'b1;
        end
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic write_addr(input int idx, input logic [AW-1:0] a);
        @(negedge clk);
        sta_valid = 1'b1; sta_idx = IW'(idx); sta_addr = a;
        @(negedge clk);
        sta_valid = 1'b0;
    endtask

    task automatic write_data(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        std_valid = 1'b1; std_idx = IW'(idx); std_data = d;
        @(negedge clk);
        std_valid = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [PW-1:0] p,
                          input logic [1:0] ev, input logic [DW-1:0] ed, input string tag);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_pos = p;
        #1;
        check(ld_verdict == ev, tag, ld_verdict, ev);
        if (ev == 2'd1) check(ld_data == ed, tag, ld_data, ed);
        ld_valid = 1'b0;
    endtask

    task automatic drain(input int n, input int stall, input int base);
        int got = 0;
        int retired = 0;
        for (int cyc = 0; cyc < 80 && got < n; cyc++) begin
            @(negedge clk);
            retire_valid = (retired < n);
            if (retire_valid) retired++;
            cache_wr_ready = (cyc >= stall);
            #1;
            if (cache_wr_valid) begin
                check(cache_wr_addr == exp_a[base+got], "R9 order addr", cache_wr_addr, exp_a[base+got]);
                check(cache_wr_data == exp_d[base+got], "R9 order data", cache_wr_data, exp_d[base+got]);
                if (cache_wr_ready) got++;
            end
        end
        @(negedge clk);
        retire_valid = 1'b0;
        cache_wr_ready = 1'b0;
        check(got == n, "R9 write count", got, n);
    endtask

    initial begin
        #(5.0 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        check(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
        check(alloc_ptr == 0, "R1 alloc_ptr", alloc_ptr, 0);
        check(cache_wr_valid == 1'b0, "R1 cache_wr_valid", cache_wr_valid, 0);
        check(ld_verdict == 2'd0, "R1 verdict", ld_verdict, 0);

        // six stores; entry 3 address and entry 4 value held back
        do_alloc(6);
        check(alloc_ptr == 6, "R2 ptr advance", alloc_ptr, 6);
        write_addr(5, 32'h200); write_data(5, 32'hA5);
        write_addr(0, 32'h100); write_data(0, 32'hA0);
        write_addr(2, 32'h100); write_data(2, 32'hA2);
        write_addr(1, 32'h200); write_data(1, 32'hA1);
        write_addr(4, 32'h300); write_data(3, 32'hA3);

        for (int v = 0; v < NV; v++) begin
            lookup(V_ADDR[v], V_POS[v], V_VERD[v], V_DATA[v], v_tag[v]);
        end

        // R3: no load presented
        @(negedge clk); ld_valid = 1'b0; ld_addr = 32'h100; ld_pos = 4'd6; #1;
        check(ld_verdict == 2'd0, "R3 idle verdict", ld_verdict, 0);

        write_addr(3, 32'h500);
        write_data(4, 32'hA4);
        lookup(32'h300, 4'd5, 2'd1, 32'hA4, "R8 value now ready");
        lookup(32'h100, 4'd6, 2'd1, 32'hA2, "R7 unknown resolved");

        drain(6, 3, 0);
        @(negedge clk); #1;
        check(alloc_ready == 1'b1, "R12 free after drain", alloc_ready, 1);

        // R9: retire with nothing uncommitted
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            retire_valid = (c < 2);
            cache_wr_ready = 1'b1;
            #1;
            check(cache_wr_valid == 1'b0, "R9 extra retire ignored", cache_wr_valid, 0);
        end
        retire_valid = 1'b0; cache_wr_ready = 1'b0;

        // wrap: eight stores at pointers 6..13
        do_alloc(8);
        #1;
        check(alloc_ready == 1'b0, "R2 full", alloc_ready, 0);
        check(alloc_ptr == 14, "R2 full ptr", alloc_ptr, 14);
        do_alloc(2);
        #1;
        check(alloc_ptr == 14, "R2 alloc ignored when full", alloc_ptr, 14);
        lookup(32'h100, 4'd14, 2'd3, 32'h0, "R11 reused slot unknown");

        for (int p = 6; p < 14; p++) begin
            write_addr(p % DEPTH, exp_a[p]);
            write_data(p % DEPTH, exp_d[p]);
        end
        lookup(32'h700, 4'd14, 2'd1, 32'hB1, "R10 youngest across wrap");
        lookup(32'h700, 4'd7, 2'd1, 32'hB0, "R10 window cut");
        lookup(32'h800, 4'd8, 2'd2, 32'h0, "R10 wrapped younger excluded");
        lookup(32'h800, 4'd14, 2'd1, 32'hB2, "R10 wrapped included");

        drain(8, 0, 6);
        @(negedge clk); #1;
        check(alloc_ready == 1'b1, "R12 free after wrap drain", alloc_ready, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule